// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This block rounds a wide internal mantissa to its retained width. The incoming word carries two extra low bits, a guard bit (the upper of the two) and a round bit (the lower). A separate sticky flag says whether any nonzero bits were lost further down. The unit drops guard and round, decides from the rounding mode, the sign and the discarded bits whether to add one at the retained least significant bit, and applies that increment with a carry through the whole word.

The result has one more bit than the retained fraction. A carry that turns an all-ones fraction into 2.0 therefore stays in that top bit, and renormalising it is left to the consumer. A rounded-up flag lets a downstream packer find the cases that need an exponent bump. An inexact flag reports that bits were discarded. The decision and the increment are combinational, and all outputs are registered, so results appear one clock after the inputs.

Top module: `dirround_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `mant_o`, `up_o` and `inexact_o` are all cleared to zero at that edge.
- R2: Inputs sampled at one rising edge give outputs at that same edge. `mant_o` equals `mant_i` shifted right by two, zero-extended to RES_W bits, plus `up_o`.
- R3: When `mant_i[1]` (guard), `mant_i[0]` (round) and `sticky_i` are all zero, `up_o` is 0 and `inexact_o` is 0 in every mode.
- R4: `inexact_o` is 1 whenever guard, round or `sticky_i` is 1, in every mode.
- R5: Mode 2'b00 (nearest) increments only when guard is 1 and at least one of round, `sticky_i` or the retained LSB `mant_i[2]` is 1. An exact half therefore rounds to an even result.
- R6: Mode 2'b01 (toward zero) never increments.
- R7: Mode 2'b10 (toward plus infinity) increments exactly when the result is inexact and `sign_i` is 0 (positive).
- R8: Mode 2'b11 (toward minus infinity) increments exactly when the result is inexact and `sign_i` is 1 (negative).
- R9: The increment carries across the full retained width. An all-ones retained fraction that rounds up gives `mant_o` with only its top bit (bit RES_W-1) set.
- R10: `up_o` is 1 exactly when `mant_o` is one above the retained fraction. Otherwise `mant_o` equals the retained fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mant_i | input | IN_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits lost below the round bit |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_o | output | IN_W-1 | Rounded mantissa with carry bit on top (registered) |
| up_o | output | 1 | An increment was applied (registered) |
| inexact_o | output | 1 | Guard, round or sticky was nonzero (registered) |

## Verification
Directed cases separate the modes on the few discarded-bit patterns where they disagree. An exact half with an even and then an odd retained LSB tells round-to-even apart from round-half-up. A sticky-only remainder with each sign tells the two infinity-directed modes apart from each other and from truncation. An all-ones fraction forces the carry to travel through every chunk of the increment chain into the top bit. Seeded random mantissas then sweep all modes and signs. About half of them have exact low bits, which keeps the exact path and the inexact paths both well covered.

// File: rtl/dirround_pkg.sv
package dirround_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rmode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import dirround_pkg::*;
(
  input  logic   guard_i,
  input  logic   rbit_i,
  input  logic   sticky_i,
  input  logic   lsb_i,
  input  logic   sign_i,
  input  rmode_e mode_i,
  output logic   up_o,
  output logic   inexact_o
);
  logic lost;

  always_comb begin
    lost      = guard_i | rbit_i | sticky_i;
    inexact_o = lost;
    unique case (mode_i)
      RM_ZERO: up_o = 1'b0;
      RM_POS:  up_o = lost & ~sign_i;
      RM_NEG:  up_o = lost &  sign_i;
      default: up_o = guard_i & (rbit_i | sticky_i | lsb_i);
    endcase
  end
endmodule

// File: rtl/rnd_chain_inc.sv
module rnd_chain_inc #(
  parameter int W       = 32,
  parameter int CHUNK_W = 8
) (
  input  logic [W-1:0] value_i,
  input  logic         inc_i,
  output logic [W:0]   sum_o
);
  localparam int NCH  = (W + CHUNK_W - 1) / CHUNK_W;
  localparam int PADW = NCH * CHUNK_W;

  logic [PADW-1:0] padded;
  logic [PADW:0]   padded_sum;
  logic [NCH:0]    carry;

  assign padded   = {{(PADW-W){1'b0}}, value_i};
  assign carry[0] = inc_i;

  for (genvar k = 0; k < NCH; k++) begin : g_chunk
    logic [CHUNK_W:0] part;
    assign part = {1'b0, padded[k*CHUNK_W +: CHUNK_W]} + {{CHUNK_W{1'b0}}, carry[k]};
    assign padded_sum[k*CHUNK_W +: CHUNK_W] = part[CHUNK_W-1:0];
    assign carry[k+1] = part[CHUNK_W];
  end

  assign padded_sum[PADW] = carry[NCH];
  assign sum_o = padded_sum[W:0];

  // R9
  always_comb begin
    if (!$isunknown({value_i, inc_i}))
      carry_chk: assert (sum_o == ({1'b0, value_i} + {{W{1'b0}}, inc_i}));
  end
endmodule

// File: rtl/dirround_unit.sv
module dirround_unit
  import dirround_pkg::*;
#(
  parameter int IN_W    = 34,
  parameter int CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   mant_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  output logic [IN_W-2:0]   mant_o,
  output logic              up_o,
  output logic              inexact_o
);
  localparam int FRAC_W = IN_W - 2;
  localparam int RES_W  = FRAC_W + 1;

  logic [FRAC_W-1:0] kept;
  logic              up_c;
  logic              inexact_c;
  logic [RES_W-1:0]  sum_c;
  logic              live_q;

  assign kept = mant_i[IN_W-1:2];

  rnd_decide u_decide (
    .guard_i   (mant_i[1]),
    .rbit_i    (mant_i[0]),
    .sticky_i  (sticky_i),
    .lsb_i     (mant_i[2]),
    .sign_i    (sign_i),
    .mode_i    (rmode_e'(mode_i)),
    .up_o      (up_c),
    .inexact_o (inexact_c)
  );

  rnd_chain_inc #(.W(FRAC_W), .CHUNK_W(CHUNK_W)) u_inc (
    .value_i (kept),
    .inc_i   (up_c),
    .sum_o   (sum_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mant_o    <= '0;
      up_o      <= 1'b0;
      inexact_o <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      mant_o    <= sum_c;
      up_o      <= up_c;
      inexact_o <= inexact_c;
      live_q    <= 1'b1;
    end
  end

  // R3
  exact_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mant_i[1:0] == 2'b00 && !sticky_i)) |-> (!up_o && !inexact_o));
  // R4
  inexact_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mant_i[1] | mant_i[0] | sticky_i)) |-> inexact_o);
  // R6
  rtz_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mode_i) == 2'b01) |-> !up_o);
  // R7
  pos_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mode_i) == 2'b10) |-> (up_o == (inexact_o && !$past(sign_i))));
  // R8
  neg_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mode_i) == 2'b11) |-> (up_o == (inexact_o && $past(sign_i))));
  // R10
  up_sum_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (mant_o == ({1'b0, $past(mant_i[IN_W-1:2])} + {{FRAC_W{1'b0}}, up_o})));
endmodule

// File: tb/dirround_unit_test.sv
`timescale 1ns/1ps
module dirround_unit_test;
  localparam int IN_W  = 34;
  localparam int RES_W = IN_W - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [IN_W-1:0]   mant_i = '0;
  logic              sticky_i = 1'b0;
  logic              sign_i = 1'b0;
  logic [1:0]        mode_i = 2'b00;
  logic [RES_W-1:0]  mant_o;
  logic              up_o;
  logic              inexact_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dirround_unit #(.IN_W(IN_W), .CHUNK_W(8)) uut (
    .clk(clk), .rst(rst), .mant_i(mant_i), .sticky_i(sticky_i),
    .sign_i(sign_i), .mode_i(mode_i),
    .mant_o(mant_o), .up_o(up_o), .inexact_o(inexact_o)
  );

  function automatic logic want_up(logic [IN_W-1:0] m, logic s, logic sg, logic [1:0] md);
    logic g, r, l;
    g = m[1]; r = m[0]; l = m[2];
    case (md)
      2'b01:   return 1'b0;
      2'b10:   return (g | r | s) & ~sg;
      2'b11:   return (g | r | s) & sg;
      default: return g & (r | s | l);
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [IN_W-1:0] m, logic s, logic sg, logic [1:0] md, string tag);
    logic             eu;
    logic [RES_W-1:0] er;
    @(negedge clk);
    mant_i = m; sticky_i = s; sign_i = sg; mode_i = md;
    eu = want_up(m, s, sg, md);
    er = {1'b0, m[IN_W-1:2]} + {{(RES_W-1){1'b0}}, eu};
    @(negedge clk);
    chk({tag, " up"}, 64'(up_o), 64'(eu));
    chk({tag, " inexact"}, 64'(inexact_o), 64'(m[1] | m[0] | s));
    chk({tag, " mant"}, 64'(mant_o), 64'(er));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    // R1: reset clears outputs
    chk("R1 mant", 64'(mant_o), 64'd0);
    chk("R1 up", 64'(up_o), 64'd0);
    chk("R1 inexact", 64'(inexact_o), 64'd0);
    rst = 1'b0;

    // R3: exact in every mode
    for (int md = 0; md < 4; md++) begin
      apply(34'h2_AAAA_5554, 1'b0, md[0], 2'(md), "R3 exact");
      if (up_o !== 1'b0 || inexact_o !== 1'b0) chk("R3 flags", 64'({up_o, inexact_o}), 64'd0);
    end
    // R5: ties to even, plus above/below half
    apply(34'h0_0000_0012, 1'b0, 1'b0, 2'b00, "R5 tie even");
    chk("R5 tie even stays", 64'(up_o), 64'd0);
    apply(34'h0_0000_0016, 1'b0, 1'b0, 2'b00, "R5 tie odd");
    chk("R5 tie odd bumps", 64'(up_o), 64'd1);
    apply(34'h0_0000_0013, 1'b0, 1'b1, 2'b00, "R5 above half");
    apply(34'h0_0000_0011, 1'b1, 1'b0, 2'b00, "R5 below half");
    apply(34'h0_0000_0010, 1'b1, 1'b1, 2'b00, "R4 sticky only");
    chk("R4 sticky raises inexact", 64'(inexact_o), 64'd1);
    // R6: toward zero
    apply(34'h1_2345_6787, 1'b1, 1'b0, 2'b01, "R6 trunc pos");
    apply(34'h1_2345_6787, 1'b1, 1'b1, 2'b01, "R6 trunc neg");
    chk("R6 no bump", 64'(up_o), 64'd0);
    // R7 / R8: directed infinities with sticky only
    apply(34'h0_0000_0100, 1'b1, 1'b0, 2'b10, "R7 pos");
    chk("R7 pos bumps", 64'(up_o), 64'd1);
    apply(34'h0_0000_0100, 1'b1, 1'b1, 2'b10, "R7 neg");
    apply(34'h0_0000_0100, 1'b1, 1'b1, 2'b11, "R8 neg");
    chk("R8 neg bumps", 64'(up_o), 64'd1);
    apply(34'h0_0000_0100, 1'b1, 1'b0, 2'b11, "R8 pos");
    // R9: carry through whole width
    apply(34'h3_FFFF_FFFE, 1'b0, 1'b0, 2'b00, "R9 carry");
    chk("R9 top bit only", 64'(mant_o), 64'h1_0000_0000);

    // R2 R10: seeded random sweep
    for (int i = 0; i < 400; i++) begin
      logic [IN_W-1:0] m;
      logic s;
      m = {$urandom, $urandom};
      s = 1'($urandom);
      if ($urandom % 2 == 0) begin m[1:0] = 2'b00; s = 1'b0; end
      apply(m, s, 1'($urandom), 2'($urandom), "R2 R10 rand");
    end

    // R1: reset after a nonzero result
    apply(34'h3_FFFF_FFFF, 1'b1, 1'b0, 2'b10, "R2 pre-reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 late mant", 64'(mant_o), 64'd0);
    chk("R1 late up", 64'(up_o), 64'd0);
    chk("R1 late inexact", 64'(inexact_o), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule